// File: doc/BRIEF.md
# Masked Vector Broadcast Unit

This unit copies one scalar from a 64-bit general-purpose input into every element of a vector destination of up to 512 bits. The element width can be 8, 16, 32 or 64 bits and is decoded from an opcode byte and a width-select bit. The active vector length can be 128, 256 or 512 bits.

A per-element writemask decides which elements receive the scalar. Elements whose mask bit is clear either keep their old destination contents (merge mode) or are cleared (zero mode). Every bit above the active vector length is always cleared.

A reserved 4-bit operand field, a reserved vector-length code and unknown opcodes raise an invalid-opcode flag. When the flag is raised, the destination is returned unchanged. The result and the flag are registered, so each request produces its answer one clock later.

Top module: `vbc_top`

## Requirements
- R1: The element size comes from the opcode byte: 0x7A gives 8-bit elements, 0x7B gives 16-bit, 0x7C with wBit=0 gives 32-bit, and 0x7C with wBit=1 in long mode gives 64-bit. Any other opcode raises illegalOp.
- R2: vlCode selects the active length: 0 means 128 bits, 1 means 256 bits, 2 means 512 bits. The element count is the active length divided by the element width.
- R3: Element j (bits j*W up to j*W+W-1) takes scalarIn[W-1:0] when maskIn[j] is 1 or when maskSel is 0. maskSel=0 means no writemask, and every element is then written.
- R4: With zeroMode=0 (merge), an element whose mask bit is clear keeps the value it has in oldDest.
- R5: With zeroMode=1 (zero), an element whose mask bit is clear becomes all zeros.
- R6: Every destOut bit at or above the active length is 0 in a valid, legal result.
- R7: If vvvvIn is not 4'b1111, illegalOp is 1 and destOut equals the oldDest of that request.
- R8: When longMode=0, wBit has no effect: opcode 0x7C always broadcasts 32-bit elements.
- R9: Mask bits at index equal to or above the element count have no effect on destOut.
- R10: vlCode=2'b11 is reserved: illegalOp is 1 and destOut equals oldDest.
- R11: outValid is inValid delayed by one clock. destOut and illegalOp change only in the cycle after inValid. Reset clears outValid, destOut and illegalOp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe |
| scalarIn | input | 64 | Scalar source value |
| oldDest | input | 512 | Current destination contents |
| maskIn | input | 64 | Per-element writemask, bit j for element j |
| maskSel | input | 3 | Mask register selector, 0 means no mask |
| zeroMode | input | 1 | 1: zero-masking, 0: merge-masking |
| vlCode | input | 2 | Vector length code (0:128, 1:256, 2:512, 3:reserved) |
| opByte | input | 8 | Decoded opcode byte |
| wBit | input | 1 | Width-select bit |
| vvvvIn | input | 4 | Reserved operand field, must be 4'b1111 |
| longMode | input | 1 | 1 when executing in 64-bit mode |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| destOut | output | 512 | New destination value |
| illegalOp | output | 1 | Invalid-opcode flag for the result |

## Verification
The bench builds the unit with its default parameters: a 512-bit vector and a 64-bit scalar. These defaults make every combination of element width and vector length reachable, including the 512-bit length and the widest mask of 64 element bits. This lets the cases that clear the upper bits be checked, as well as a mask whose set bits lie entirely above the element count. Directed requests cover each width/length pair, merge against zero mode and every illegal-field case. A stream of pseudo-random legal and illegal requests follows, with idle gaps that test whether the outputs hold.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
  localparam logic [7:0] OP_BYTE_ELEM = 8'h7A;
  localparam logic [7:0] OP_WORD_ELEM = 8'h7B;
  localparam logic [7:0] OP_WIDE_ELEM = 8'h7C;
  localparam logic [3:0] VVVV_UNUSED  = 4'b1111;
  localparam logic [1:0] VL_RESERVED  = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic [1:0] sizeLog2;  // log2 of element size in bytes
    logic [1:0] vlLog;     // 0:128, 1:256, 2:512
    logic       maskOn;
    logic       zeroOn;
    logic       illegal;
  } bcStrobes_t;
endpackage

// File: rtl/vbc_ctrl.sv
module vbc_ctrl
  import vbc_pkg::*;
(
  input  logic [7:0] opByte,
  input  logic       wBit,
  input  logic [3:0] vvvvIn,
  input  logic       longMode,
  input  logic [1:0] vlCode,
  input  logic [2:0] maskSel,
  input  logic       zeroMode,
  output bcStrobes_t strobes
);
  logic badOpcode;

  always_comb begin
    badOpcode        = 1'b0;
    strobes.sizeLog2 = 2'd0;
    unique case (opByte)
      OP_BYTE_ELEM: strobes.sizeLog2 = 2'd0;
      OP_WORD_ELEM: strobes.sizeLog2 = 2'd1;
      // the width bit only counts in long mode (R8)
      OP_WIDE_ELEM: strobes.sizeLog2 = (longMode && wBit) ? 2'd3 : 2'd2;
      default:      badOpcode = 1'b1;
    endcase
    strobes.vlLog   = vlCode;
    strobes.maskOn  = (maskSel != 3'd0);
    strobes.zeroOn  = zeroMode;
    strobes.illegal = badOpcode || (vvvvIn != VVVV_UNUSED) || (vlCode == VL_RESERVED);
  end

  // R8: no quadword decode outside long mode
  always_comb begin
    if (longMode == 1'b0) begin
      a_no_quad_short_r8: assert (strobes.sizeLog2 != 2'd3);
    end
  end
endmodule

// File: rtl/vbc_datapath.sv
module vbc_datapath
  import vbc_pkg::*;
#(
  parameter int unsigned VEC_W    = 512,
  parameter int unsigned SCALAR_W = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  bcStrobes_t                  strobes,
  input  logic [SCALAR_W-1:0]         scalarIn,
  input  logic [VEC_W-1:0]            oldDest,
  input  logic [VEC_W/8-1:0]          maskIn,
  output logic                        outValid,
  output logic [VEC_W-1:0]            destOut,
  output logic                        illegalOp
);
  localparam int unsigned LANES      = VEC_W / 8;
  localparam int unsigned IDX_W      = $clog2(LANES);
  localparam int unsigned SUB_W      = $clog2(SCALAR_W / 8);
  localparam int unsigned MIN_LANES  = 16;

  logic [IDX_W:0]         activeLanes;
  logic [LANES-1:0][7:0]  nextDest;

  assign activeLanes = (IDX_W + 1)'(MIN_LANES) << strobes.vlLog;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDX_W-1:0] laneIdx;
    logic [IDX_W-1:0] elemIdx;
    logic [SUB_W-1:0] subIdx;
    logic             inRange;
    logic             takeNew;

    assign laneIdx = IDX_W'(g);
    assign elemIdx = laneIdx >> strobes.sizeLog2;
    assign subIdx  = SUB_W'(laneIdx & ((IDX_W'(1) << strobes.sizeLog2) - IDX_W'(1)));
    assign inRange = {1'b0, laneIdx} < activeLanes;
    assign takeNew = !strobes.maskOn || maskIn[elemIdx];
    assign nextDest[g] = !inRange ? 8'h00 :
                         takeNew  ? scalarIn[subIdx*8 +: 8] :
                         strobes.zeroOn ? 8'h00 : oldDest[g*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      destOut   <= '0;
      illegalOp <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        illegalOp <= strobes.illegal;
        destOut   <= strobes.illegal ? oldDest : nextDest;
      end
    end
  end

  // R11: one-cycle latency, outputs hold while idle
  p_latency_r11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(destOut) && $stable(illegalOp)));
  // R6: above 128 bits nothing survives at the shortest length
  p_upper_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !strobes.illegal && strobes.vlLog == 2'd0) |=> (destOut[VEC_W-1:128] == '0));
endmodule

// File: rtl/vbc_top.sv
module vbc_top
  import vbc_pkg::*;
#(
  parameter int unsigned VEC_W    = 512,
  parameter int unsigned SCALAR_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SCALAR_W-1:0] scalarIn,
  input  logic [VEC_W-1:0]    oldDest,
  input  logic [VEC_W/8-1:0]  maskIn,
  input  logic [2:0]          maskSel,
  input  logic                zeroMode,
  input  logic [1:0]          vlCode,
  input  logic [7:0]          opByte,
  input  logic                wBit,
  input  logic [3:0]          vvvvIn,
  input  logic                longMode,
  output logic                outValid,
  output logic [VEC_W-1:0]    destOut,
  output logic                illegalOp
);
  bcStrobes_t strobes;

  vbc_ctrl ctrl_i (
    .opByte   (opByte),
    .wBit     (wBit),
    .vvvvIn   (vvvvIn),
    .longMode (longMode),
    .vlCode   (vlCode),
    .maskSel  (maskSel),
    .zeroMode (zeroMode),
    .strobes  (strobes)
  );

  vbc_datapath #(.VEC_W(VEC_W), .SCALAR_W(SCALAR_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .strobes   (strobes),
    .scalarIn  (scalarIn),
    .oldDest   (oldDest),
    .maskIn    (maskIn),
    .outValid  (outValid),
    .destOut   (destOut),
    .illegalOp (illegalOp)
  );

  // R7: a used reserved field flags the request
  p_vvvv_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && vvvvIn != VVVV_UNUSED) |=> illegalOp);
  // R7 / R10: a flagged result passes the old destination through
  p_illegal_keeps_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (vvvvIn != VVVV_UNUSED || vlCode == VL_RESERVED)) |=> (destOut == $past(oldDest)));
  // R10: reserved vector-length code
  p_vl_reserved_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && vlCode == VL_RESERVED) |=> illegalOp);
endmodule

// File: tb/vbc_top_tb.sv
module vbc_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [63:0]  scalarIn;
  logic [511:0] oldDest;
  logic [63:0]  maskIn;
  logic [2:0]   maskSel;
  logic         zeroMode;
  logic [1:0]   vlCode;
  logic [7:0]   opByte;
  logic         wBit;
  logic [3:0]   vvvvIn;
  logic         longMode;
  logic         outValid;
  logic [511:0] destOut;
  logic         illegalOp;

  int    nTests = 0;
  int    nFail  = 0;
  bit    done   = 0;
  string curTag = "R11";

  // expected outputs (behavioural model)
  logic         expV = 1'b0;
  logic [511:0] expD = '0;
  logic         expI = 1'b0;
  string        expTag = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  vbc_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .scalarIn(scalarIn),
    .oldDest(oldDest), .maskIn(maskIn), .maskSel(maskSel), .zeroMode(zeroMode),
    .vlCode(vlCode), .opByte(opByte), .wBit(wBit), .vvvvIn(vvvvIn),
    .longMode(longMode), .outValid(outValid), .destOut(destOut), .illegalOp(illegalOp)
  );

  task automatic refModel(output logic [511:0] d, output logic ill);
    int ebits;
    int vbits;
    ill   = 1'b0;
    ebits = 8;
    case (opByte)
      8'h7A: ebits = 8;
      8'h7B: ebits = 16;
      8'h7C: ebits = (longMode && wBit) ? 64 : 32;
      default: ill = 1'b1;
    endcase
    if (vvvvIn != 4'hF) ill = 1'b1;
    if (vlCode == 2'd3) ill = 1'b1;
    if (ill) begin
      d = oldDest;
    end else begin
      vbits = 128 * (1 << vlCode);
      for (int i = 0; i < 512; i++) begin
        if (i >= vbits) d[i] = 1'b0;
        else if (maskSel == 0 || maskIn[i / ebits]) d[i] = scalarIn[i % ebits];
        else if (zeroMode) d[i] = 1'b0;
        else d[i] = oldDest[i];
      end
    end
  endtask

  always @(posedge clk) begin
    logic [511:0] d;
    logic         ill;
    if (!rstN) begin
      expV = 1'b0; expD = '0; expI = 1'b0;
    end else begin
      expV = inValid;
      if (inValid) begin
        refModel(d, ill);
        expD = d;
        expI = ill;
      end
    end
    expTag = curTag;
  end

  always @(negedge clk) begin
    if (!done && rstN !== 1'bx) begin
      nTests++;
      if (outValid !== expV || destOut !== expD || illegalOp !== expI) begin
        nFail++;
        $display("FAIL %s: valid=%b ill=%b dest=%h | expected valid=%b ill=%b dest=%h",
                 expTag, outValid, illegalOp, destOut, expV, expI, expD);
      end
    end
  end

  task automatic issue(input string tag, input logic [7:0] op, input logic w, input logic lm,
                       input logic [1:0] vl, input logic [2:0] sel, input logic zm,
                       input logic [63:0] msk, input logic [63:0] sc, input logic [3:0] vv);
    @(negedge clk);
    curTag   = tag;
    inValid  = 1'b1;
    opByte   = op; wBit = w; longMode = lm; vlCode = vl;
    maskSel  = sel; zeroMode = zm; maskIn = msk; scalarIn = sc; vvvvIn = vv;
    oldDest  = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
                $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic idle(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      curTag  = tag;
      inValid = 1'b0;
      oldDest = ~oldDest;
      scalarIn = ~scalarIn;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      nFail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; scalarIn = '0; oldDest = '0; maskIn = '0;
    maskSel = '0; zeroMode = 1'b0; vlCode = '0; opByte = '0; wBit = 1'b0;
    vvvvIn = 4'hF; longMode = 1'b1;
    repeat (3) @(negedge clk);   // reset state checked by R11 comparisons
    rstN = 1'b1;
    // R1 byte, R4 merge, 128 bits (R6)
    issue("R1_byte_R4", 8'h7A, 0, 1, 2'd0, 3'd1, 0, 64'h0000_0000_0000_A5C3, 64'h1122_3344_5566_77EE, 4'hF);
    // R1 word, R5 zero, 256 bits (R2)
    issue("R1_word_R5", 8'h7B, 0, 1, 2'd1, 3'd2, 1, 64'h0000_0000_F0F0_1234, 64'h0000_0000_0000_BEEF, 4'hF);
    // R1 dword, 512 bits (R2)
    issue("R1_dword_R2", 8'h7C, 0, 1, 2'd2, 3'd3, 0, 64'h0000_0000_0000_9A5F, 64'hFFFF_FFFF_CAFE_F00D, 4'hF);
    // R1 quad, long mode
    issue("R1_quad", 8'h7C, 1, 1, 2'd2, 3'd4, 1, 64'h0000_0000_0000_00B5, 64'h0123_4567_89AB_CDEF, 4'hF);
    // R8 width bit ignored outside long mode
    issue("R8_short_mode", 8'h7C, 1, 0, 2'd2, 3'd0, 0, 64'h0, 64'h0123_4567_89AB_CDEF, 4'hF);
    // R3 no writemask with all-zero mask
    issue("R3_nomask", 8'h7A, 0, 1, 2'd1, 3'd0, 1, 64'h0, 64'h0000_0000_0000_005A, 4'hF);
    // R7 reserved field used
    issue("R7_vvvv", 8'h7B, 0, 1, 2'd2, 3'd0, 0, 64'hFFFF, 64'h1234, 4'b1110);
    // R10 reserved length
    issue("R10_vl3", 8'h7A, 0, 1, 2'd3, 3'd0, 0, 64'h0, 64'h77, 4'hF);
    // R1 unknown opcode
    issue("R1_badop", 8'h7D, 0, 1, 2'd0, 3'd0, 0, 64'h0, 64'h77, 4'hF);
    // R9 mask bits above element count ignored
    issue("R9_highmask", 8'h7A, 0, 1, 2'd0, 3'd1, 0, 64'hFFFF_FFFF_FFFF_0000, 64'h99, 4'hF);
    issue("R9_highmask_q", 8'h7C, 1, 1, 2'd0, 3'd1, 1, 64'hFFFF_FFFF_FFFF_FFFC, 64'h5555_AAAA_5555_AAAA, 4'hF);
    // R11 idle gaps hold outputs
    idle("R11_hold", 3);
    // R3 mixed stream
    for (int n = 0; n < 300; n++) begin
      logic [7:0] op;
      logic [1:0] vl;
      logic [3:0] vv;
      case ($urandom % 4)
        0: op = 8'h7A;
        1: op = 8'h7B;
        2: op = 8'h7C;
        default: op = ($urandom % 8 == 0) ? 8'h10 : 8'h7C;
      endcase
      vl = ($urandom % 16 == 0) ? 2'd3 : 2'($urandom % 3);
      vv = ($urandom % 16 == 0) ? 4'($urandom) : 4'hF;
      issue("R3_mix", op, 1'($urandom), 1'($urandom), vl, 3'($urandom), 1'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom}, vv);
      if ($urandom % 5 == 0) idle("R11_gap", 1);
    end
    idle("R11_end", 2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule